// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the shared register file for a bank of up to twelve DMA channel engines. It stores each channel's transfer mode and transfer direction, holds an interrupt enable for every channel, and gathers the per-channel engine state together with sticky interrupt and error flags into packed status words. A host reads and writes it over a simple 32-bit register port. The channel engines drive the live 2-bit state and single-cycle event pulses into it, and they take their mode and direction back from it.

The channels sit in two groups: the first eight and the remaining four. Each group has its own control word and its own status word, and the bit offsets differ between the groups. Status flags clear when a 1 is written to them, so a host may acknowledge everything it saw by writing back the value it read. A single level interrupt goes to the host while any enabled channel has its interrupt flag set. The register port has no handshake: a write takes effect at the clock edge on which `reg_wen` is high, and a read is a combinational view of the addressed word. Reads have no side effects. Channel count `NUM_CH` must lie between 1 and 12; fields of channels that are not present read 0.

Top module: `dmacsr_regs`

## Requirements
- R1: After reset, every register reads 0 apart from the live state fields, all mode and direction outputs are 0, and `host_irq` is 0.
- R2: Offset 0x00 holds a 4-bit field per channel c below 8 at bits 4c+3:4c. Bits 1:0 of the field are the mode and bit 2 is the direction, and bit 3 always reads 0. `ch_mode`/`ch_dir` take the written value on the edge of the write.
- R3: Offset 0x0C holds the same 4-bit fields for channels 8 to 11, at field index c-8 (bits 15:0). Bits 31:16 read 0.
- R4: Offset 0x08 holds the interrupt enables: bit c for channel c below 8, and bit c+8 (bits 19:16) for channels 8 to 11. All other bits read 0 and writes to them are ignored.
- R5: Offset 0x10 reads interrupt flag c at bit c and error flag c at bit c+8 for channels 0 to 7. The live state `ch_state` of channel c is at bits 17+2c:16+2c.
- R6: Offset 0x18 reads the interrupt flag of channel c (8 to 11) at bit c-8, its error flag at bit c, and its live state at bits 17+2(c-8):16+2(c-8).
- R7: A one-cycle pulse on `ch_irq_pulse[c]` or `ch_err_pulse[c]` sets the matching flag, which stays set through later pulses until the host writes 1 to that flag bit. Writing 0 leaves the flag unchanged.
- R8: When a pulse and a write of 1 to the same flag fall on the same edge, the flag ends up set.
- R9: `host_irq` is high exactly while some channel has both its interrupt flag and its enable set. It follows the registered flags and enables without added delay.
- R10: Offsets 0x04, 0x14 and 0x1C read 0 and writes to them change nothing. The state fields are read-only. A write to one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Byte offset of the addressed register |
| reg_wen | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the addressed register |
| ch_state | input | 2*NUM_CH | Live 2-bit state of each channel engine |
| ch_irq_pulse | input | NUM_CH | Per-channel interrupt event pulse |
| ch_err_pulse | input | NUM_CH | Per-channel error event pulse |
| ch_mode | output | 2*NUM_CH | Per-channel mode, 2 bits each |
| ch_dir | output | NUM_CH | Per-channel direction |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands on the same edge as a new event for the very flag it clears. A host that does a read-modify-write can only hit that race by chance. The stimulus forces it by driving the event pulse and the clearing write together in one cycle. It then continues with a long randomized run of mixed writes, pulses and state changes, while a behavioural model is compared on every clock. The model also covers the split between the two channel groups, whose offsets differ in each register.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 5;
  localparam int MAX_CH     = 12;
  localparam int LO_GROUP   = 8;   // channels in the first register group
  localparam int FLD_W      = 4;   // control field pitch
  localparam int ST_W       = 2;   // engine state width
  localparam int ST_BASE    = 16;  // first state bit in a status word
  localparam int ERR_BASE   = 8;   // error flag offset inside a status word
  localparam int HI_EN_BASE = 16;  // enable bit of the first high-group channel

  localparam logic [ADDR_W-1:0] A_CTL0 = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTL1 = 5'h04;
  localparam logic [ADDR_W-1:0] A_CTL2 = 5'h08;
  localparam logic [ADDR_W-1:0] A_CTL3 = 5'h0C;
  localparam logic [ADDR_W-1:0] A_STS0 = 5'h10;
  localparam logic [ADDR_W-1:0] A_STS1 = 5'h14;
  localparam logic [ADDR_W-1:0] A_STS2 = 5'h18;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_LIST   = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_RSVD   = 2'd3
  } chan_mode_e;

  typedef struct packed {
    logic       dir;
    chan_mode_e mode;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/dmacsr_cfg_slot.sv
module dmacsr_cfg_slot
  import dmacsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  chan_cfg_t cfg_wval,
  input  logic      en_we,
  input  logic      en_wval,
  output chan_cfg_t cfg_q,
  output logic      en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wval;
      if (en_we)  en_q  <= en_wval;
    end
  end

  // R2 / R3: configuration only moves on a write to its own word
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_wval));
  // R4: enable only moves on a write to the enable word
  a_r4_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));
endmodule

// File: rtl/dmacsr_flag_slot.sv
module dmacsr_flag_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  // R8: a new event beats a simultaneous acknowledge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R7: acknowledge clears, nothing else does
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/dmacsr_regs.sv
module dmacsr_regs
  import dmacsr_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wen,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  input  logic [ST_W*NUM_CH-1:0] ch_state,
  input  logic [NUM_CH-1:0]      ch_irq_pulse,
  input  logic [NUM_CH-1:0]      ch_err_pulse,
  output logic [2*NUM_CH-1:0]    ch_mode,
  output logic [NUM_CH-1:0]      ch_dir,
  output logic                   host_irq
);
  chan_cfg_t         cfg_q [NUM_CH];
  logic [NUM_CH-1:0] irq_en;
  logic [NUM_CH-1:0] irq_flag;
  logic [NUM_CH-1:0] err_flag;

  logic wr_ctl0, wr_ctl2, wr_ctl3, wr_sts0, wr_sts2;
  assign wr_ctl0 = reg_wen && (reg_addr == A_CTL0);
  assign wr_ctl2 = reg_wen && (reg_addr == A_CTL2);
  assign wr_ctl3 = reg_wen && (reg_addr == A_CTL3);
  assign wr_sts0 = reg_wen && (reg_addr == A_STS0);
  assign wr_sts2 = reg_wen && (reg_addr == A_STS2);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam bit HI     = (c >= LO_GROUP);
    localparam int IX     = c % LO_GROUP;
    localparam int EN_BIT = HI ? HI_EN_BASE + IX : IX;

    logic      cfg_we, sts_we, clr_irq, clr_err;
    chan_cfg_t cfg_wval;

    assign cfg_we   = HI ? wr_ctl3 : wr_ctl0;
    assign sts_we   = HI ? wr_sts2 : wr_sts0;
    assign cfg_wval = chan_cfg_t'(reg_wdata[FLD_W*IX +: CFG_W]);
    assign clr_irq  = sts_we & reg_wdata[IX];
    assign clr_err  = sts_we & reg_wdata[ERR_BASE+IX];

    dmacsr_cfg_slot u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we),
      .cfg_wval(cfg_wval),
      .en_we   (wr_ctl2),
      .en_wval (reg_wdata[EN_BIT]),
      .cfg_q   (cfg_q[c]),
      .en_q    (irq_en[c])
    );

    dmacsr_flag_slot u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ch_irq_pulse[c]),
      .clr_i (clr_irq),
      .flag_q(irq_flag[c])
    );

    dmacsr_flag_slot u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ch_err_pulse[c]),
      .clr_i (clr_err),
      .flag_q(err_flag[c])
    );

    assign ch_mode[2*c +: 2] = cfg_q[c].mode;
    assign ch_dir[c]         = cfg_q[c].dir;
  end

  // packed read views of both groups
  logic [REG_W-1:0] ctl0_w, ctl2_w, ctl3_w, sts0_w, sts2_w;
  always_comb begin
    ctl0_w = '0;
    ctl2_w = '0;
    ctl3_w = '0;
    sts0_w = '0;
    sts2_w = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      int ix;
      ix = c % LO_GROUP;
      if (c < LO_GROUP) begin
        ctl0_w[FLD_W*ix +: CFG_W]       = cfg_q[c];
        ctl2_w[ix]                      = irq_en[c];
        sts0_w[ix]                      = irq_flag[c];
        sts0_w[ERR_BASE+ix]             = err_flag[c];
        sts0_w[ST_BASE+ST_W*ix +: ST_W] = ch_state[ST_W*c +: ST_W];
      end else begin
        ctl3_w[FLD_W*ix +: CFG_W]       = cfg_q[c];
        ctl2_w[HI_EN_BASE+ix]           = irq_en[c];
        sts2_w[ix]                      = irq_flag[c];
        sts2_w[ERR_BASE+ix]             = err_flag[c];
        sts2_w[ST_BASE+ST_W*ix +: ST_W] = ch_state[ST_W*c +: ST_W];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL0:  reg_rdata = ctl0_w;
      A_CTL2:  reg_rdata = ctl2_w;
      A_CTL3:  reg_rdata = ctl3_w;
      A_STS0:  reg_rdata = sts0_w;
      A_STS2:  reg_rdata = sts2_w;
      default: reg_rdata = '0;
    endcase
  end

  assign host_irq = |(irq_flag & irq_en);

  // R9: no pending flag means no host interrupt
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag == '0) |-> !host_irq);
  // R9: host line rises only after a flag or enable change
  a_r9_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> (irq_flag != $past(irq_flag) || irq_en != $past(irq_en)));
  // R10: unused offsets read zero
  a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTL1 || reg_addr == A_STS1) |-> reg_rdata == '0);
endmodule

// File: tb/tb_dmacsr_regs.sv
`timescale 1ns/1ps
module tb_dmacsr_regs;
  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic          reg_wen = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [2*N-1:0] ch_state = '0;
  logic [N-1:0]  ch_irq_pulse = '0;
  logic [N-1:0]  ch_err_pulse = '0;
  logic [2*N-1:0] ch_mode;
  logic [N-1:0]  ch_dir;
  logic          host_irq;

  always #4 clk = ~clk;

  dmacsr_regs #(.NUM_CH(N)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_state(ch_state),
    .ch_irq_pulse(ch_irq_pulse), .ch_err_pulse(ch_err_pulse),
    .ch_mode(ch_mode), .ch_dir(ch_dir), .host_irq(host_irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model
  bit [1:0] m_mode [N];
  bit       m_dir  [N];
  bit       m_en   [N];
  bit       m_irq  [N];
  bit       m_err  [N];

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      m_mode[c] = 0; m_dir[c] = 0; m_en[c] = 0; m_irq[c] = 0; m_err[c] = 0;
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      model_reset();
      return;
    end
    for (int c = 0; c < N; c++) begin
      int k;
      bit clr_i, clr_e;
      k = (c < 8) ? c : c - 8;
      if (reg_wen && c < 8 && reg_addr == 5'h00) begin
        m_mode[c] = reg_wdata[4*k +: 2]; m_dir[c] = reg_wdata[4*k+2];
      end
      if (reg_wen && c >= 8 && reg_addr == 5'h0C) begin
        m_mode[c] = reg_wdata[4*k +: 2]; m_dir[c] = reg_wdata[4*k+2];
      end
      if (reg_wen && reg_addr == 5'h08)
        m_en[c] = (c < 8) ? reg_wdata[c] : reg_wdata[c+8];
      clr_i = reg_wen && reg_addr == ((c < 8) ? 5'h10 : 5'h18) && reg_wdata[k];
      clr_e = reg_wen && reg_addr == ((c < 8) ? 5'h10 : 5'h18) && reg_wdata[k+8];
      if (ch_irq_pulse[c]) m_irq[c] = 1; else if (clr_i) m_irq[c] = 0;
      if (ch_err_pulse[c]) m_err[c] = 1; else if (clr_e) m_err[c] = 0;
    end
  endtask

  function automatic logic [31:0] mread(logic [4:0] a);
    logic [31:0] w;
    w = '0;
    for (int c = 0; c < N; c++) begin
      int k;
      k = (c < 8) ? c : c - 8;
      if (c < 8) begin
        if (a == 5'h00) begin w[4*k +: 2] = m_mode[c]; w[4*k+2] = m_dir[c]; end
        if (a == 5'h08) w[c] = m_en[c];
        if (a == 5'h10) begin
          w[k] = m_irq[c]; w[k+8] = m_err[c]; w[16+2*k +: 2] = ch_state[2*c +: 2];
        end
      end else begin
        if (a == 5'h0C) begin w[4*k +: 2] = m_mode[c]; w[4*k+2] = m_dir[c]; end
        if (a == 5'h08) w[c+8] = m_en[c];
        if (a == 5'h18) begin
          w[k] = m_irq[c]; w[k+8] = m_err[c]; w[16+2*k +: 2] = ch_state[2*c +: 2];
        end
      end
    end
    return w;
  endfunction

  function automatic bit mirq();
    bit r;
    r = 0;
    for (int c = 0; c < N; c++) r |= m_irq[c] & m_en[c];
    return r;
  endfunction

  task automatic compare_all();
    logic [31:0] er;
    er = mread(reg_addr);
    checks++;
    if (reg_rdata !== er) begin
      errors++;
      $display("FAIL %s rdata @%h actual %h expected %h", cur_req, reg_addr, reg_rdata, er);
    end
    for (int c = 0; c < N; c++) begin
      checks++;
      if (ch_mode[2*c +: 2] !== m_mode[c] || ch_dir[c] !== m_dir[c]) begin
        errors++;
        $display("FAIL %s ch%0d cfg actual %0d/%0d expected %0d/%0d",
                 (c < 8) ? "R2" : "R3", c, ch_mode[2*c +: 2], ch_dir[c], m_mode[c], m_dir[c]);
      end
    end
    checks++;
    if (host_irq !== mirq()) begin
      errors++;
      $display("FAIL R9 host_irq actual %b expected %b", host_irq, mirq());
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic cyc(input logic [4:0] a, input bit we, input logic [31:0] d,
                     input logic [N-1:0] ip, input logic [N-1:0] ep);
    reg_addr = a; reg_wen = we; reg_wdata = d; ch_irq_pulse = ip; ch_err_pulse = ep;
    tick();
    reg_wen = 0; ch_irq_pulse = '0; ch_err_pulse = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(a, 1, d, '0, '0);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read @%h actual %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements) actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();

    // R1: reset state
    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd(5'(4*a), 32'h0, "R1");
    chk_bit(host_irq, 1'b0, "R1 host_irq");
    chk_bit(|ch_mode, 1'b0, "R1 ch_mode");

    // R2: low group control word
    cur_req = "R2";
    wr(5'h00, 32'hFEDC_BA98);
    rd(5'h00, 32'h7654_3210, "R2 bit3 dropped");
    chk_bit(ch_mode[15], 1'b1, "R2 ch7 mode msb");
    chk_bit(ch_dir[7], 1'b1, "R2 ch7 dir");
    chk_bit(ch_dir[0], 1'b0, "R2 ch0 dir");

    // R3: high group control word
    cur_req = "R3";
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, 32'h0000_7777, "R3");
    rd(5'h00, 32'h7654_3210, "R3 low group untouched");
    chk_bit(ch_dir[11], 1'b1, "R3 ch11 dir");

    // R10: reserved offsets
    cur_req = "R10";
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h04, 32'h0, "R10 ctl1");
    rd(5'h14, 32'h0, "R10 sts1");
    rd(5'h1C, 32'h0, "R10 gap");
    rd(5'h00, 32'h7654_3210, "R10 ctl0 kept");
    rd(5'h08, 32'h0, "R10 enables kept");

    // R5 / R6: live state fields
    cur_req = "R5";
    ch_state = 24'hA5_C396;
    rd(5'h10, 32'hC396_0000, "R5 state");
    rd(5'h18, 32'h00A5_0000, "R6 state");
    ch_state = '0;

    // R7 / R9: flags with enables off
    cur_req = "R7";
    cyc(5'h10, 0, 0, 12'b0100_0000_1000, 12'b0010_0010_0000);
    rd(5'h10, 32'h0000_2008, "R5 flags");
    rd(5'h18, 32'h0000_0204, "R6 flags");
    chk_bit(host_irq, 1'b0, "R9 masked");

    // R4 / R9: enables
    cur_req = "R4";
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, 32'h000F_00FF, "R4");
    chk_bit(host_irq, 1'b1, "R9 enabled");

    // R7: sticky and write-1-to-clear
    cur_req = "R7";
    cyc(5'h10, 0, 0, 12'b0000_0000_1000, '0);
    rd(5'h10, 32'h0000_2008, "R7 repeat pulse");
    wr(5'h10, 32'h0);
    rd(5'h10, 32'h0000_2008, "R7 write zero");
    wr(5'h10, 32'hFFFF_2008);
    rd(5'h10, 32'h0, "R7 writeback clears, R10 state ro");
    rd(5'h18, 32'h0000_0204, "R7 other group kept");
    chk_bit(host_irq, 1'b1, "R9 ch10 pending");
    wr(5'h18, 32'h0000_0204);
    rd(5'h18, 32'h0, "R7 group2 clear");
    chk_bit(host_irq, 1'b0, "R9 all clear");

    // R8: event and acknowledge on the same edge
    cur_req = "R8";
    cyc(5'h10, 1, 32'h0000_0001, 12'b0000_0000_0001, '0);
    rd(5'h10, 32'h0000_0001, "R8 irq set wins");
    cyc(5'h18, 1, 32'h0000_0800, '0, 12'b1000_0000_0000);
    rd(5'h18, 32'h0000_0800, "R8 err set wins");

    // R9: disabling the enable drops the line
    cur_req = "R9";
    wr(5'h08, 32'h0);
    chk_bit(host_irq, 1'b0, "R9 disabled");
    wr(5'h08, 32'h0001_0001);
    chk_bit(host_irq, 1'b1, "R9 ch0 enable");

    // randomized run against the model
    cur_req = "R7/R10 random";
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      a = 5'(4 * ($urandom % 8));
      ch_state = 24'($urandom);
      cyc(a, ($urandom % 2) == 1, $urandom,
          ($urandom % 3 == 0) ? 12'($urandom) : '0,
          ($urandom % 4 == 0) ? 12'($urandom) : '0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule